// File: doc/BRIEF.md
# Protection Page Register File

This block holds two small pages that sit beside the main memory array of a serial EEPROM with access protection. The first is a 16-byte control page and the second is a 16-byte identification page. The control page carries, for each of eight memory blocks, a volatile lock bit, a two-bit access field and a two-bit legacy field. It also holds one more access field that guards the upper control bytes and the identification page, eight write-enable bits for the pages of block 0, an emulated coil-detect handshake, three plain bytes, a byte that always reads all ones, and a fixed revision byte.

A command sequencer hands the block one data byte at a time. With each byte it gives a word address, a flag that says whether this is the first data byte of the transfer, and an allow signal from the permission checker. The block returns the acknowledge decision in the same cycle. Reads are combinational on the word address. The stored access fields and the page write enables are exported to the permission checker. A power-up reset restores the erased state. A low protect input forces the lock bits back to 1 and leaves the stored fields as they are.

Top module: `prot_page_regfile`

## Requirements
- R1: After `rst`, control bytes 0–7 read B3h, byte 8 reads 83h, byte 9 reads FFh, byte 10 reads 40h, bytes 11–13 and every identification byte read FFh, byte 14 reads FFh and byte 15 reads 10h.
- R2: A control byte 0–7 holds its lock bit in bit 7, a legacy field in bits 5:4 and an access field in bits 1:0. A write that is applied loads these three fields from the data byte.
- R3: A lock bit can only be cleared by a write. A write with data bit 7 at 0 clears it, and a write with data bit 7 at 1 leaves it at 1.
- R4: While the lock bit of a control byte (0–8) is 0, writes to that byte are acknowledged and change nothing.
- R5: While `prot_n` is low, all nine lock bits are forced to 1 and the stored fields keep their values. Afterwards a write to the byte is applied again.
- R6: Byte 9 holds the eight block-0 page write enables. Bit 0 covers the first page. The byte is driven on `pg_wen` and changes only on an acknowledged write.
- R7: In byte 10, bit 7 is the detect-enable bit (writable) and bit 6 is the detect-status bit (read-only). Writing bit 7 as 1 clears bit 6, and bit 6 never returns to 1 until `rst`. Bit 0 always reads 0.
- R8: Byte 14 always reads FFh and byte 15 always reads 10h. Writes to them are acknowledged and ignored.
- R9: Bytes 11–13 and the identification bytes at word addresses 10h–1Fh are plain read/write storage.
- R10: `wr_ack` is 1 only when the address has bits 7:5 all 0, `wr_first` is 1 and `wr_allow` is 1. A write that is not acknowledged changes nothing, and an out-of-range address reads 00h.
- R11: Don't-care bits read 0: bits 6, 3 and 2 of bytes 0–7, bits 6:2 of byte 8, and bits 5:1 of byte 10.
- R12: Byte 8 holds its lock bit in bit 7 and, in bits 1:0, the access field that guards the upper page. That field is driven on `ap_pb`. The access field of block i is driven on `blk_pb[2i+1:2i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| prot_n | input | 1 | Protect input, active low; forces the lock bits to 1 |
| wr_req | input | 1 | Data byte write strobe from the sequencer |
| wr_first | input | 1 | The data byte is the first of its transfer |
| wr_allow | input | 1 | Permission checker allows this write |
| addr | input | 8 | Word address (00h–0Fh control page, 10h–1Fh identification page) |
| wr_data | input | 8 | Write data byte |
| wr_ack | output | 1 | Acknowledge for the current data byte |
| rd_data | output | 8 | Composed byte at `addr` |
| blk_pb | output | 16 | Access fields of the eight blocks, two bits each |
| ap_pb | output | 2 | Access field guarding the upper page |
| pg_wen | output | 8 | Block-0 page write enables |

## Verification
`wr_ack` and `rd_data` are combinational. The bench samples them one time unit after the rising edge at which the stimulus is held, in the same cycle. An applied write takes effect at the edge that closes its request cycle, and every result of that write (`rd_data`, `blk_pb`, `ap_pb`, `pg_wen`) is due from the next cycle. The driver therefore lowers the strobe at the following falling edge and schedules any read-back no earlier than the cycle after. A protect pulse must cover one rising edge, and its effect is checked one cycle after the pulse is released.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int NBLK       = 8;
    localparam int BYTE_W     = 8;
    localparam int NCTL       = NBLK + 1;
    localparam int IDX_W      = 4;
    localparam int OFS_AP     = NBLK;
    localparam int OFS_PGEN   = NBLK + 1;
    localparam int OFS_COIL   = NBLK + 2;
    localparam int OFS_USER   = NBLK + 3;
    localparam int NUSER      = 3;
    localparam int OFS_FILL   = 14;
    localparam int OFS_REV    = 15;
    localparam int NID        = 16;
    localparam logic [BYTE_W-1:0] FILL_VAL = 8'hFF;
    localparam logic [BYTE_W-1:0] REV_VAL  = 8'h10;

    typedef struct packed {
        logic [1:0] rf;
        logic [1:0] pb;
    } blk_ctl_t;

    typedef enum logic [3:0] {
        SEL_CTL, SEL_AP, SEL_PGEN, SEL_COIL, SEL_USER,
        SEL_FILL, SEL_REV, SEL_ID, SEL_NONE
    } sel_e;

    function automatic sel_e decode_sel(input logic [7:0] a);
        sel_e s;
        if (a[7:5] != 3'b000)                    s = SEL_NONE;
        else if (a[4])                           s = SEL_ID;
        else if (int'(a[3:0]) < NBLK)            s = SEL_CTL;
        else if (int'(a[3:0]) == OFS_AP)         s = SEL_AP;
        else if (int'(a[3:0]) == OFS_PGEN)       s = SEL_PGEN;
        else if (int'(a[3:0]) == OFS_COIL)       s = SEL_COIL;
        else if (int'(a[3:0]) < OFS_FILL)        s = SEL_USER;
        else if (int'(a[3:0]) == OFS_FILL)       s = SEL_FILL;
        else                                     s = SEL_REV;
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctl(input logic lock, input blk_ctl_t c);
        return {lock, 1'b0, c.rf, 2'b00, c.pb};
    endfunction

endpackage

// File: rtl/ppr_decode.sv
module ppr_decode
    import prot_pkg::*;
(
    input  logic       wr_req,
    input  logic       wr_first,
    input  logic       wr_allow,
    input  logic [7:0] addr,
    output sel_e       sel,
    output logic [IDX_W-1:0] idx,
    output logic       ack,
    output logic       wen
);
    always_comb begin
        sel = decode_sel(addr);
        idx = addr[IDX_W-1:0];
        ack = (sel != SEL_NONE) && wr_first && wr_allow;
        wen = wr_req && ack;
    end
endmodule

// File: rtl/ppr_lock_bank.sv
module ppr_lock_bank
    import prot_pkg::*;
#(
    parameter int N = NCTL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_n,
    input  logic              wen,
    input  sel_e              sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [N-1:0]      lock_q,
    output blk_ctl_t          ctl_q [N]
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic hit;
        always_comb begin
            if (g < NBLK) hit = wen && (sel == SEL_CTL) && (int'(idx) == g);
            else          hit = wen && (sel == SEL_AP);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[g]   <= 1'b1;
                ctl_q[g].pb <= 2'b11;
            end else if (!prot_n) begin
                lock_q[g]   <= 1'b1;
            end else if (hit && lock_q[g]) begin
                lock_q[g]   <= wdata[7];
                ctl_q[g].pb <= wdata[1:0];
            end
        end

        if (g < NBLK) begin : g_rf
            always_ff @(posedge clk) begin
                if (rst)                                 ctl_q[g].rf <= 2'b11;
                else if (prot_n && hit && lock_q[g])     ctl_q[g].rf <= wdata[5:4];
            end
        end else begin : g_norf
            always_comb ctl_q[g].rf = 2'b00;
        end

        // R5
        lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(lock_q[g]) |-> !$past(prot_n));

        // R4
        locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!lock_q[g] && prot_n) |=> $stable(ctl_q[g]));
    end
endmodule

// File: rtl/ppr_misc_regs.sv
module ppr_misc_regs
    import prot_pkg::*;
#(
    parameter int NU = NUSER,
    parameter int NI = NID
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wen,
    input  sel_e              sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] pgen_q,
    output logic              de_q,
    output logic              dc_q,
    output logic [BYTE_W-1:0] user_q [NU],
    output logic [BYTE_W-1:0] id_q [NI]
);
    always_ff @(posedge clk) begin
        if (rst)                            pgen_q <= '1;
        else if (wen && sel == SEL_PGEN)    pgen_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            de_q <= 1'b0;
            dc_q <= 1'b1;
        end else if (wen && sel == SEL_COIL) begin
            de_q <= wdata[7];
            if (wdata[7]) dc_q <= 1'b0;
        end
    end

    for (genvar u = 0; u < NU; u++) begin : g_user
        always_ff @(posedge clk) begin
            if (rst)                                                    user_q[u] <= '1;
            else if (wen && sel == SEL_USER && int'(idx) == OFS_USER + u) user_q[u] <= wdata;
        end
    end

    for (genvar i = 0; i < NI; i++) begin : g_id
        always_ff @(posedge clk) begin
            if (rst)                                          id_q[i] <= '1;
            else if (wen && sel == SEL_ID && int'(idx) == i)  id_q[i] <= wdata;
        end
    end

    // R7
    dc_never_rise_chk: assert property (@(posedge clk) disable iff (rst) !$rose(dc_q));

    // R7
    coil_excl_chk: assert property (@(posedge clk) disable iff (rst) de_q |-> !dc_q);
endmodule

// File: rtl/prot_page_regfile.sv
module prot_page_regfile
    import prot_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                prot_n,
    input  logic                wr_req,
    input  logic                wr_first,
    input  logic                wr_allow,
    input  logic [7:0]          addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic                wr_ack,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [2*NBLK-1:0]   blk_pb,
    output logic [1:0]          ap_pb,
    output logic [BYTE_W-1:0]   pg_wen
);
    sel_e              sel;
    logic [IDX_W-1:0]  idx;
    logic              wen;
    logic [NCTL-1:0]   lock_q;
    blk_ctl_t          ctl_q [NCTL];
    logic              de_q, dc_q;
    logic [BYTE_W-1:0] user_q [NUSER];
    logic [BYTE_W-1:0] id_q [NID];

    ppr_decode u_dec (
        .wr_req(wr_req), .wr_first(wr_first), .wr_allow(wr_allow), .addr(addr),
        .sel(sel), .idx(idx), .ack(wr_ack), .wen(wen)
    );

    ppr_lock_bank #(.N(NCTL)) u_lock (
        .clk(clk), .rst(rst), .prot_n(prot_n), .wen(wen), .sel(sel), .idx(idx),
        .wdata(wr_data), .lock_q(lock_q), .ctl_q(ctl_q)
    );

    ppr_misc_regs #(.NU(NUSER), .NI(NID)) u_misc (
        .clk(clk), .rst(rst), .wen(wen), .sel(sel), .idx(idx), .wdata(wr_data),
        .pgen_q(pg_wen), .de_q(de_q), .dc_q(dc_q), .user_q(user_q), .id_q(id_q)
    );

    for (genvar b = 0; b < NBLK; b++) begin : g_pb
        assign blk_pb[2*b +: 2] = ctl_q[b].pb;
    end
    assign ap_pb = ctl_q[OFS_AP].pb;

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_CTL:  rd_data = pack_ctl(lock_q[idx[2:0]], ctl_q[idx[2:0]]);
            SEL_AP:   rd_data = pack_ctl(lock_q[OFS_AP], ctl_q[OFS_AP]);
            SEL_PGEN: rd_data = pg_wen;
            SEL_COIL: rd_data = {de_q, dc_q, 6'b000000};
            SEL_USER: rd_data = user_q[int'(idx) - OFS_USER];
            SEL_FILL: rd_data = FILL_VAL;
            SEL_REV:  rd_data = REV_VAL;
            SEL_ID:   rd_data = id_q[idx];
            default:  rd_data = '0;
        endcase
    end

    // R6
    pgen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_req && wr_ack) |=> $stable(pg_wen));
endmodule

// File: tb/test_prot_page_regfile.sv
module test_prot_page_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prot_n = 1'b1;
    logic        wr_req = 1'b0, wr_first = 1'b0, wr_allow = 1'b0;
    logic [7:0]  addr = '0, wr_data = '0;
    logic        wr_ack;
    logic [7:0]  rd_data, pg_wen;
    logic [15:0] blk_pb;
    logic [1:0]  ap_pb;

    always #5 clk = ~clk;

    prot_page_regfile i_prot_page_regfile (
        .clk(clk), .rst(rst), .prot_n(prot_n), .wr_req(wr_req), .wr_first(wr_first),
        .wr_allow(wr_allow), .addr(addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .rd_data(rd_data), .blk_pb(blk_pb), .ap_pb(ap_pb), .pg_wen(pg_wen)
    );

    typedef struct {
        int          kind;   // 0 rd_data, 1 wr_ack, 2 pg_wen, 3 blk_pb, 4 ap_pb
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_run = 0, n_fail = 0;
    bit    done = 1'b0;

    initial begin
        forever begin
            wait (q.size() > 0);
            @(posedge clk);
            #1;
            begin
                item_t it;
                logic [15:0] act;
                it = q.pop_front();
                case (it.kind)
                    0: act = {8'h00, rd_data};
                    1: act = {15'h0, wr_ack};
                    2: act = {8'h00, pg_wen};
                    3: act = blk_pb;
                    default: act = {14'h0, ap_pb};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push_wait(input int kind, input logic [15:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(posedge clk);
        #2;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a;
        push_wait(0, {8'h00, e}, tag);
    endtask

    task automatic port(input int kind, input logic [15:0] e, input string tag);
        @(negedge clk);
        push_wait(kind, e, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic first,
                      input logic allow, input logic exp_ack, input string tag);
        @(negedge clk);
        addr = a; wr_data = d; wr_first = first; wr_allow = allow; wr_req = 1'b1;
        push_wait(1, {15'h0, exp_ack}, tag);
        @(negedge clk);
        wr_req = 1'b0; wr_first = 1'b0; wr_allow = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(8'h00, 8'hB3, "R1 ctl0");
        rd(8'h07, 8'hB3, "R1 ctl7");
        rd(8'h08, 8'h83, "R1 ap byte");
        rd(8'h09, 8'hFF, "R1 pgen");
        rd(8'h0A, 8'h40, "R1 coil");
        rd(8'h0C, 8'hFF, "R1 user");
        rd(8'h0E, 8'hFF, "R1 fill");
        rd(8'h0F, 8'h10, "R1 rev");
        rd(8'h13, 8'hFF, "R1 id");
        port(3, 16'hFFFF, "R1 blk_pb");

        // R2 / R12 field layout and export
        wr(8'h02, 8'h91, 1, 1, 1, "R2 ack");
        rd(8'h02, 8'h91, "R2 readback");
        port(3, 16'hFFDF, "R12 blk_pb block2");

        // R11 don't-care bits read 0
        wr(8'h03, 8'hFF, 1, 1, 1, "R11 ack");
        rd(8'h03, 8'hB3, "R11 ctl3");

        // R3 clear lock
        wr(8'h02, 8'h22, 1, 1, 1, "R3 ack");
        rd(8'h02, 8'h22, "R3 lock cleared");
        port(3, 16'hFFEF, "R3 blk_pb");

        // R4 locked byte acks and ignores
        wr(8'h02, 8'hB3, 1, 1, 1, "R4 ack while locked");
        rd(8'h02, 8'h22, "R4 unchanged");

        // R5 protect pulse
        @(negedge clk) prot_n = 1'b0;
        @(negedge clk) prot_n = 1'b1;
        rd(8'h02, 8'hA2, "R5 lock forced");
        wr(8'h02, 8'hB1, 1, 1, 1, "R5 ack");
        rd(8'h02, 8'hB1, "R5 write applies again");

        // R12 / R4 byte 8
        wr(8'h08, 8'h7E, 1, 1, 1, "R12 ack");
        rd(8'h08, 8'h02, "R12 ap byte");
        port(4, 16'h0002, "R12 ap_pb");
        wr(8'h08, 8'h83, 1, 1, 1, "R4 ap ack");
        rd(8'h08, 8'h02, "R4 ap unchanged");

        // R6 page enables
        wr(8'h09, 8'h05, 1, 1, 1, "R6 ack");
        port(2, 16'h0005, "R6 pg_wen");
        rd(8'h09, 8'h05, "R6 readback");

        // R7 coil detect
        wr(8'h0A, 8'h41, 1, 1, 1, "R7 ack");
        rd(8'h0A, 8'h40, "R7 status read-only");
        wr(8'h0A, 8'h80, 1, 1, 1, "R7 ack enable");
        rd(8'h0A, 8'h80, "R7 enable clears status");
        wr(8'h0A, 8'h7F, 1, 1, 1, "R7 ack clear");
        rd(8'h0A, 8'h00, "R7 status stays 0");

        // R8 fixed bytes
        wr(8'h0E, 8'h00, 1, 1, 1, "R8 fill ack");
        rd(8'h0E, 8'hFF, "R8 fill");
        wr(8'h0F, 8'h55, 1, 1, 1, "R8 rev ack");
        rd(8'h0F, 8'h10, "R8 rev");

        // R9 storage
        wr(8'h0C, 8'h3C, 1, 1, 1, "R9 ack");
        rd(8'h0C, 8'h3C, "R9 user");
        rd(8'h0B, 8'hFF, "R9 neighbour");
        wr(8'h1A, 8'hA5, 1, 1, 1, "R9 id ack");
        rd(8'h1A, 8'hA5, "R9 id");
        rd(8'h10, 8'hFF, "R9 id other");

        // R10 acknowledge rules
        wr(8'h0C, 8'h00, 0, 1, 0, "R10 second byte nack");
        rd(8'h0C, 8'h3C, "R10 second byte ignored");
        wr(8'h0C, 8'h11, 1, 0, 0, "R10 disallowed nack");
        rd(8'h0C, 8'h3C, "R10 disallowed ignored");
        wr(8'h2C, 8'h00, 1, 1, 0, "R10 range nack");
        rd(8'h0C, 8'h3C, "R10 range no alias");
        rd(8'h2C, 8'h00, "R10 range reads 0");
        wr(8'h09, 8'hFF, 0, 1, 0, "R10 pgen nack");
        port(2, 16'h0005, "R10 pg_wen unchanged");

        wait (q.size() == 0);
        #20;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule